// File: doc/BRIEF.md
# Offset Test Chart Pattern Generator

This block produces a built-in RGB test frame on its own. No video input is involved. By default the frame is 768 pixels wide and 768 lines tall. A 512x512 chart window sits inside the frame, 128 pixels in from the left edge and 128 lines down from the top edge. The window is filled with eight vertical color bars, each 64 pixels wide. Every pixel outside the window is black.

The block runs from the fast frame-store clock. It moves to a new pixel only once every `CLK_DIV` cycles (two by default), and it marks the last cycle of each pixel with a capture strobe. Along with the color it drives three markers: a chart-valid flag, a line-start marker and a frame-start marker. A source multiplexer that follows the block captures the color and markers on the strobe. The enable input starts the raster. When enable is dropped, the raster returns to pixel (0,0), so the next run always begins at the top-left corner.

All geometry is set by parameters, and each value is checked at elaboration.

Top module: `test_chart_gen`

## Requirements
- R1: While `en` is high, `pix_ce` is high in exactly one cycle out of every `CLK_DIV` (default 2), and consecutive strobes are exactly `CLK_DIV` cycles apart. Each pixel is held for `CLK_DIV` cycles, and `pix_ce` marks its last cycle.
- R2: Pixels are visited in raster order. The column runs from 0 to `FRAME_W-1` and then returns to 0, and at that point the line advances by one. The line runs from 0 to `FRAME_H-1` and then returns to 0.
- R3: A pixel outside the chart window has `rgb` equal to all zero.
- R4: Inside the window, the bar index is (column - `OFS_X`) / `BAR_W`, which runs from 0 to 7. The bars are, in index order: 0 white, 1 yellow, 2 cyan, 3 green, 4 magenta, 5 red, 6 blue, 7 black. Each primary is either all ones or all zeros. `rgb` packs red in bits [23:16], green in bits [15:8] and blue in bits [7:0].
- R5: `pix_valid` is high exactly when the column lies in [`OFS_X`, `OFS_X+CHART_W-1`] and the line lies in [`OFS_Y`, `OFS_Y+CHART_H-1`]. By default both ranges are [128, 639].
- R6: `line_start` is high for the whole period of every pixel in column 0 and low for every other pixel.
- R7: `frame_start` is high only for the period of pixel (0,0).
- R8: While `en` is low, all outputs are zero and both counters are cleared. After `en` rises, the first pixel shown is (0,0), with `frame_start` high at once. Its strobe comes `CLK_DIV-1` cycles after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-store clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the raster; low clears it |
| pix_ce | output | 1 | Capture strobe, one cycle per pixel |
| pix_valid | output | 1 | Current pixel lies inside the chart window |
| line_start | output | 1 | Current pixel is in column 0 |
| frame_start | output | 1 | Current pixel is (0,0) |
| rgb | output | 3*CW | Pixel color {R,G,B} |

## Verification
A column or line counter that is off by one, or that returns to 0 at the wrong place, shifts the whole picture. The scoreboard sees this as a color or valid mismatch at the very next window edge or bar boundary, within one line. A phase counter with the wrong period shows up as a strobe spacing error at the second pixel. A clear that fails when enable drops shows up on the first strobe of the next run, because that pixel does not arrive as (0,0) with `frame_start` set. The bench checks every pixel of two whole frames plus a partial run, so every corner of the window, every bar edge and every pixel just outside the window is compared.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
   localparam int NUM_BARS = 8;
   localparam int BAR_IDX_W = $clog2(NUM_BARS);

   typedef logic [BAR_IDX_W-1:0] bar_idx_t;

   typedef struct packed {
      logic r;
      logic g;
      logic b;
   } prim_t;

   // Primary mask per bar: white, yellow, cyan, green, magenta, red, blue, black
   function automatic prim_t bar_prim(bar_idx_t idx);
      prim_t p;
      p.r = ~idx[1];
      p.g = ~idx[2];
      p.b = ~idx[0];
      return p;
   endfunction
endpackage

// File: rtl/tcg_pacer.sv
module tcg_pacer #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (CLK_DIV == 1) begin : g_full_rate
         assign tick = en;
      end else begin : g_divided
         localparam int PW = $clog2(CLK_DIV);
         localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (!en) begin
               phase <= '0;
            end else if (phase == LAST) begin
               phase <= '0;
            end else begin
               phase <= phase + PW'(1);
            end
         end

         assign tick = en && (phase == LAST);

         AST_CE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick) else $error("strobe on back-to-back cycles"); // R1
      end
   endgenerate
endmodule

// File: rtl/tcg_raster.sv
module tcg_raster #(
   parameter int FRAME_W = 768,
   parameter int FRAME_H = 768,
   localparam int XW = $clog2(FRAME_W),
   localparam int YW = $clog2(FRAME_H)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   output logic [XW-1:0] hx,
   output logic [YW-1:0] vy
);
   localparam logic [XW-1:0] X_LAST = XW'(FRAME_W - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(FRAME_H - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hx <= '0;
         vy <= '0;
      end else if (!en) begin
         hx <= '0;
         vy <= '0;
      end else if (tick) begin
         if (hx == X_LAST) begin
            hx <= '0;
            vy <= (vy == Y_LAST) ? '0 : vy + YW'(1);
         end else begin
            hx <= hx + XW'(1);
         end
      end
   end

   AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (hx == '0 && vy == '0)) else $error("raster not cleared"); // R8
   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(hx)) else $error("column moved without strobe"); // R1
   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hx == X_LAST) |=> (hx == '0)) else $error("column did not wrap"); // R2
   AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(hx) < FRAME_W) && (32'(vy) < FRAME_H)) else $error("coordinate out of frame"); // R2
endmodule

// File: rtl/tcg_colorizer.sv
module tcg_colorizer
   import tcg_pkg::*;
#(
   parameter int FRAME_W = 768,
   parameter int FRAME_H = 768,
   parameter int CHART_W = 512,
   parameter int CHART_H = 512,
   parameter int OFS_X   = 128,
   parameter int OFS_Y   = 128,
   parameter int BAR_W   = 64,
   parameter int CW      = 8,
   localparam int XW = $clog2(FRAME_W),
   localparam int YW = $clog2(FRAME_H)
) (
   input  logic          en,
   input  logic [XW-1:0] hx,
   input  logic [YW-1:0] vy,
   output logic [3*CW-1:0] rgb,
   output logic          in_chart,
   output logic          line_start,
   output logic          frame_start
);
   localparam int BSH = $clog2(BAR_W);

   logic          in_x, in_y;
   logic [XW-1:0] dx;
   bar_idx_t      idx;
   prim_t         prim;

   always_comb begin
      in_x = (32'(hx) >= OFS_X) && (32'(hx) < OFS_X + CHART_W);
      in_y = (32'(vy) >= OFS_Y) && (32'(vy) < OFS_Y + CHART_H);
      dx   = hx - XW'(OFS_X);
      idx  = BAR_IDX_W'(dx >> BSH);
      prim = bar_prim(idx);
      in_chart    = en && in_x && in_y;
      line_start  = en && (hx == '0);
      frame_start = en && (hx == '0) && (vy == '0);
      if (in_chart) begin
         rgb = {{CW{prim.r}}, {CW{prim.g}}, {CW{prim.b}}};
      end else begin
         rgb = '0;
      end
   end
endmodule

// File: rtl/test_chart_gen.sv
module test_chart_gen #(
   parameter int FRAME_W = 768,
   parameter int FRAME_H = 768,
   parameter int CHART_W = 512,
   parameter int CHART_H = 512,
   parameter int OFS_X   = 128,
   parameter int OFS_Y   = 128,
   parameter int BAR_W   = 64,
   parameter int CLK_DIV = 2,
   parameter int CW      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   output logic            pix_ce,
   output logic            pix_valid,
   output logic            line_start,
   output logic            frame_start,
   output logic [3*CW-1:0] rgb
);
   localparam int XW = $clog2(FRAME_W);
   localparam int YW = $clog2(FRAME_H);

   initial begin
      assert (CHART_W == tcg_pkg::NUM_BARS * BAR_W) else $error("chart width must hold eight bars");
      assert ((BAR_W & (BAR_W - 1)) == 0 && BAR_W > 0) else $error("bar width must be a power of two");
      assert (OFS_X + CHART_W <= FRAME_W) else $error("chart exceeds frame width");
      assert (OFS_Y + CHART_H <= FRAME_H) else $error("chart exceeds frame height");
      assert (CLK_DIV >= 1 && CW >= 1) else $error("bad divider or color width");
      assert (FRAME_W >= 2 && FRAME_H >= 2) else $error("frame too small");
   end

   logic          tick;
   logic [XW-1:0] hx;
   logic [YW-1:0] vy;

   tcg_pacer #(.CLK_DIV(CLK_DIV)) u_pacer (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
   );

   tcg_raster #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_raster (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .hx(hx), .vy(vy)
   );

   tcg_colorizer #(
      .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .CHART_W(CHART_W), .CHART_H(CHART_H),
      .OFS_X(OFS_X), .OFS_Y(OFS_Y), .BAR_W(BAR_W), .CW(CW)
   ) u_color (
      .en(en), .hx(hx), .vy(vy), .rgb(rgb), .in_chart(pix_valid),
      .line_start(line_start), .frame_start(frame_start)
   );

   assign pix_ce = tick;

   AST_FRAME_IMPLIES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start) else $error("frame marker without line marker"); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!pix_ce && !pix_valid && !line_start && rgb == '0)) else $error("output while disabled"); // R8
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !pix_ce && en) |=> (frame_start || !en)) else $error("frame marker cut short"); // R7
endmodule

// File: tb/test_chart_gen_tb.sv
`timescale 1ns/1ps
module test_chart_gen_tb;
   localparam int FW = 48, FH = 40, CWD = 32, CHT = 24, OX = 8, OY = 6, BW = 4, DIV = 2, CW = 8;

   typedef struct {
      int         x;
      int         y;
      logic [23:0] rgb;
      logic       valid;
      logic       ls;
      logic       fs;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
   logic pix_ce, pix_valid, line_start, frame_start;
   logic [3*CW-1:0] rgb;

   int checks = 0, failures = 0;
   item_t q[$];
   int gap = 0;
   bit have_prev = 0;

   always #5 clk = ~clk;

   test_chart_gen #(
      .FRAME_W(FW), .FRAME_H(FH), .CHART_W(CWD), .CHART_H(CHT),
      .OFS_X(OX), .OFS_Y(OY), .BAR_W(BW), .CLK_DIV(DIV), .CW(CW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .pix_ce(pix_ce), .pix_valid(pix_valid),
      .line_start(line_start), .frame_start(frame_start), .rgb(rgb)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic item_t model(input int x, input int y);
      item_t it;
      int idx;
      it.x = x; it.y = y;
      it.valid = (x >= OX) && (x < OX + CWD) && (y >= OY) && (y < OY + CHT);
      it.ls = (x == 0);
      it.fs = (x == 0) && (y == 0);
      it.rgb = 24'h000000;
      if (it.valid) begin
         idx = (x - OX) / BW;
         case (idx)
            0: it.rgb = 24'hFFFFFF; // white
            1: it.rgb = 24'hFFFF00; // yellow
            2: it.rgb = 24'h00FFFF; // cyan
            3: it.rgb = 24'h00FF00; // green
            4: it.rgb = 24'hFF00FF; // magenta
            5: it.rgb = 24'hFF0000; // red
            6: it.rgb = 24'h0000FF; // blue
            default: it.rgb = 24'h000000; // black
         endcase
      end
      return it;
   endfunction

   // Monitor: pops one expected pixel per capture strobe
   always @(negedge clk) begin
      if (!en) begin
         have_prev <= 0;
         gap <= 0;
      end else begin
         if (pix_ce) begin
            if (have_prev) chk(gap + 1 == DIV, "R1 strobe spacing", gap + 1, DIV);
            have_prev <= 1;
            gap <= 0;
            if (q.size() == 0) begin
               chk(0, "R2 unexpected pixel", 1, 0);
            end else begin
               item_t e;
               e = q.pop_front();
               if (e.valid) chk(rgb == e.rgb, $sformatf("R4 bar color (%0d,%0d)", e.x, e.y), rgb, e.rgb);
               else         chk(rgb == e.rgb, $sformatf("R3 black outside (%0d,%0d)", e.x, e.y), rgb, e.rgb);
               chk(pix_valid == e.valid, $sformatf("R5 valid (%0d,%0d)", e.x, e.y), pix_valid, e.valid);
               chk(line_start == e.ls, $sformatf("R6 line_start (%0d,%0d)", e.x, e.y), line_start, e.ls);
               chk(frame_start == e.fs, $sformatf("R7 frame_start (%0d,%0d) R2 order", e.x, e.y), frame_start, e.fs);
            end
         end else begin
            gap <= gap + 1;
         end
      end
   end

   task automatic idle_check(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(!pix_ce && !pix_valid && !line_start && !frame_start && rgb == '0,
             "R8 idle outputs", {pix_ce, pix_valid, line_start, frame_start, rgb[23:0]}, 0);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) q.push_back(model(i % FW, (i / FW) % FH));
      @(posedge clk); #1 en = 1'b1;
      @(negedge clk);
      chk(frame_start && !pix_ce, "R8 first pixel is (0,0) before strobe",
          {frame_start, pix_ce}, 2'b10);
      while (q.size() != 0) @(negedge clk);
      @(posedge clk); #1 en = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle_check(4);
      run(300);            // stop mid-frame
      idle_check(4);
      run(2 * FW * FH + 5); // two full frames plus wrap into a third
      idle_check(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule